// File: doc/BRIEF.md
# Masked Vector Broadcast Unit

This block copies one scalar into every element of a 512-bit vector destination. A per-element write mask decides, for each element, whether it takes the scalar. Elements whose mask bit is clear either keep their old value or are cleared, depending on the masking mode. Everything above the selected vector length is cleared. The element width comes from the opcode byte and the W bit. The vector length is 128, 256 or 512 bits.

The surrounding pipeline supplies the following with a one-cycle strobe:

- the scalar;
- the old destination;
- the mask word;
- the decoded encoding fields.

One cycle later the block returns the new destination and a fault flag. A malformed encoding raises the fault and returns the old destination unchanged. Internally there is a decode stage, a bank of 64 byte-lane selectors, and a two-state control machine. In state `ST_IDLE` the output is not valid. In state `ST_EMIT` the output is valid for exactly one cycle. The machine has two transitions: `go` moves from either state to `ST_EMIT` whenever `in_valid` is high, and `rest` moves to `ST_IDLE` whenever it is low.

Top module: `vbcast_unit`

## Requirements
- R1: The element width is set by `opcode`: 0x7A gives 8-bit elements, 0x7B gives 16-bit elements, 0x7C with W=0 gives 32-bit elements, and 0x7C with W=1 gives 64-bit elements.
- R2: `vl_sel` sets the active vector length: 0 gives 128 bits, 1 gives 256 bits, and 2 or 3 give 512 bits. Every result bit from the active length up to bit 511 is 0, whatever the mask and mode.
- R3: With `mask_en`=0, every active element receives the low element-width bits of `scalar`.
- R4: With `mask_en`=1 and `zero_mode`=0, an active element whose mask bit is clear keeps its `old_dst` value.
- R5: With `mask_en`=1 and `zero_mode`=1, an active element whose mask bit is clear becomes 0.
- R6: With `mode64`=0, W is ignored, so opcode 0x7C always gives 32-bit elements.
- R7: If `vvvv` is not 4'b1111, `ud_fault` is 1 and `dst` equals `old_dst`.
- R8: Any opcode other than 0x7A, 0x7B or 0x7C sets `ud_fault` to 1 and makes `dst` equal `old_dst`.
- R9: Only mask bits 0 to N-1 are used, where N is the active length divided by the element width. Higher mask bits have no effect.
- R10: `out_valid` goes high exactly one cycle after each cycle with `in_valid` high, and only then. Reset clears `out_valid` and `dst`.
- R11: Element j occupies `dst` bits [j*E+E-1 : j*E], where E is the element width, and is governed by mask bit j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: inputs are valid this cycle |
| scalar | input | 64 | Scalar value to replicate |
| old_dst | input | 512 | Previous destination contents |
| mask | input | 64 | Per-element write mask |
| mask_en | input | 1 | 1 = mask in use, 0 = write every active element |
| zero_mode | input | 1 | 1 = clear masked-off elements, 0 = keep them |
| vl_sel | input | 2 | Vector length select |
| opcode | input | 8 | Opcode byte |
| w_bit | input | 1 | W bit of the encoding |
| vvvv | input | 4 | Reserved register field, must be all ones |
| mode64 | input | 1 | 1 = 64-bit mode |
| out_valid | output | 1 | One-cycle result strobe |
| dst | output | 512 | New destination value |
| ud_fault | output | 1 | Undefined-opcode fault for the returned result |

## Verification
The assertions check three things on every strobe: the one-cycle valid timing, that a bad `vvvv` or bad opcode always raises the fault and returns `old_dst`, and that a 128-bit result has a clear upper region. Only the bench's scenarios can show the lane contents. That covers the width decode (including W being ignored outside 64-bit mode), merging versus zeroing of masked-off elements, disregard of high mask bits, and the element layout. For these the bench compares every bit against a reference model that works one element at a time.

// File: rtl/vbcast_pkg.sv
package vbcast_pkg;
    parameter int DST_W  = 512;
    parameter int SCL_W  = 64;
    localparam int NBYTE = DST_W / 8;
    localparam int SBYTE = SCL_W / 8;

    parameter logic [7:0] OPC_BYTE = 8'h7A;
    parameter logic [7:0] OPC_WORD = 8'h7B;
    parameter logic [7:0] OPC_DQ   = 8'h7C;

    typedef enum logic [1:0] {
        SZ_8  = 2'd0,
        SZ_16 = 2'd1,
        SZ_32 = 2'd2,
        SZ_64 = 2'd3
    } elem_sz_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } bc_state_e;
endpackage

// File: rtl/vbcast_decode.sv
module vbcast_decode
    import vbcast_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       w_bit,
    input  logic       mode64,
    input  logic [3:0] vvvv,
    input  logic [1:0] vl_sel,
    output elem_sz_e   elem_sz,
    output logic [1:0] vl_code,
    output logic       fault
);
    logic bad_opc;

    always_comb begin
        bad_opc = 1'b0;
        elem_sz = SZ_8;
        unique case (opcode)
            OPC_BYTE: elem_sz = SZ_8;
            OPC_WORD: elem_sz = SZ_16;
            OPC_DQ:   elem_sz = (w_bit && mode64) ? SZ_64 : SZ_32;
            default:  bad_opc = 1'b1;
        endcase
    end

    assign fault   = bad_opc || (vvvv != 4'b1111);
    assign vl_code = (vl_sel == 2'd3) ? 2'd2 : vl_sel;
endmodule

// File: rtl/vbcast_lanes.sv
module vbcast_lanes
    import vbcast_pkg::*;
#(
    parameter int LANES = NBYTE,
    parameter int SBYT  = SBYTE
) (
    input  logic [SBYT*8-1:0]  scalar,
    input  logic [LANES*8-1:0] old_dst,
    input  logic [LANES-1:0]   mask,
    input  logic               mask_en,
    input  logic               zero_mode,
    input  elem_sz_e           elem_sz,
    input  logic [1:0]         vl_code,
    output logic [LANES*8-1:0] result
);
    localparam int IW = $clog2(LANES);
    localparam int SW = $clog2(SBYT);

    logic [IW:0] act_bytes;
    assign act_bytes = (IW+1)'(16) << vl_code;

    for (genvar b = 0; b < LANES; b++) begin : g_byte
        logic [IW-1:0] elem_idx;
        logic [SW-1:0] sub_idx;
        logic          active;
        logic          take;

        assign elem_idx = IW'(b) >> elem_sz;
        assign sub_idx  = SW'(b) & ((SW'(1) << elem_sz) - SW'(1));
        assign active   = ((IW+1)'(b) < act_bytes);
        assign take     = !mask_en || mask[elem_idx];

        always_comb begin
            if (!active)
                result[b*8 +: 8] = 8'h00;
            else if (take)
                result[b*8 +: 8] = scalar[sub_idx*8 +: 8];
            else if (zero_mode)
                result[b*8 +: 8] = 8'h00;
            else
                result[b*8 +: 8] = old_dst[b*8 +: 8];
        end
    end
endmodule

// File: rtl/vbcast_unit.sv
module vbcast_unit
    import vbcast_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SCL_W-1:0] scalar,
    input  logic [DST_W-1:0] old_dst,
    input  logic [NBYTE-1:0] mask,
    input  logic             mask_en,
    input  logic             zero_mode,
    input  logic [1:0]       vl_sel,
    input  logic [7:0]       opcode,
    input  logic             w_bit,
    input  logic [3:0]       vvvv,
    input  logic             mode64,
    output logic             out_valid,
    output logic [DST_W-1:0] dst,
    output logic             ud_fault
);
    elem_sz_e         elem_sz;
    logic [1:0]       vl_code;
    logic             dec_fault;
    logic [DST_W-1:0] lane_out;
    bc_state_e        state_q, state_d;

    vbcast_decode u_dec (
        .opcode  (opcode),
        .w_bit   (w_bit),
        .mode64  (mode64),
        .vvvv    (vvvv),
        .vl_sel  (vl_sel),
        .elem_sz (elem_sz),
        .vl_code (vl_code),
        .fault   (dec_fault)
    );

    vbcast_lanes #(.LANES(NBYTE), .SBYT(SBYTE)) u_lanes (
        .scalar    (scalar),
        .old_dst   (old_dst),
        .mask      (mask),
        .mask_en   (mask_en),
        .zero_mode (zero_mode),
        .elem_sz   (elem_sz),
        .vl_code   (vl_code),
        .result    (lane_out)
    );

    // next-state: go / rest
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst      <= '0;
            ud_fault <= 1'b0;
        end else if (in_valid) begin
            dst      <= dec_fault ? old_dst : lane_out;
            ud_fault <= dec_fault;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_EMIT: out_valid = 1'b1;
            default: out_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/vbcast_unit_chk.sv
module vbcast_unit_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [511:0] old_dst,
    input logic [1:0]   vl_sel,
    input logic [7:0]   opcode,
    input logic [3:0]   vvvv,
    input logic         out_valid,
    input logic [511:0] dst,
    input logic         ud_fault
);
    logic opc_ok;
    assign opc_ok = (opcode == 8'h7A) || (opcode == 8'h7B) || (opcode == 8'h7C);

    p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_vvvv_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vvvv != 4'hF) |=> (ud_fault && dst == $past(old_dst)));

    p_opcode_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !opc_ok) |=> (ud_fault && dst == $past(old_dst)));

    p_good_no_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc_ok && vvvv == 4'hF) |=> !ud_fault);

    p_upper_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc_ok && vvvv == 4'hF && vl_sel == 2'd0) |=> (dst[511:128] == '0));
endmodule

bind vbcast_unit vbcast_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .old_dst   (old_dst),
    .vl_sel    (vl_sel),
    .opcode    (opcode),
    .vvvv      (vvvv),
    .out_valid (out_valid),
    .dst       (dst),
    .ud_fault  (ud_fault)
);

// File: tb/vbcast_unit_tb.sv
`timescale 1ns/1ps
module vbcast_unit_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [63:0]  scalar = '0;
    logic [511:0] old_dst = '0;
    logic [63:0]  mask = '0;
    logic         mask_en = 1'b0;
    logic         zero_mode = 1'b0;
    logic [1:0]   vl_sel = 2'd2;
    logic [7:0]   opcode = 8'h7A;
    logic         w_bit = 1'b0;
    logic [3:0]   vvvv = 4'hF;
    logic         mode64 = 1'b1;
    logic         out_valid;
    logic [511:0] dst;
    logic         ud_fault;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [511:0] q_dst[$];
    logic         q_flt[$];
    string        q_tag[$];

    always #2.5 clk = ~clk;

    vbcast_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .scalar(scalar),
        .old_dst(old_dst), .mask(mask), .mask_en(mask_en), .zero_mode(zero_mode),
        .vl_sel(vl_sel), .opcode(opcode), .w_bit(w_bit), .vvvv(vvvv),
        .mode64(mode64), .out_valid(out_valid), .dst(dst), .ud_fault(ud_fault)
    );

    // reference model: element by element, bit by bit
    function automatic logic [512:0] model(
        logic [63:0] s, logic [511:0] od, logic [63:0] m, logic men, logic zm,
        logic [1:0] vl, logic [7:0] opc, logic w, logic [3:0] v, logic m64);
        int esz;
        int vbits;
        logic [511:0] r;
        if (v != 4'hF) return {1'b1, od};
        if (opc == 8'h7A) esz = 8;
        else if (opc == 8'h7B) esz = 16;
        else if (opc == 8'h7C) esz = (w && m64) ? 64 : 32;
        else return {1'b1, od};
        vbits = (vl == 2'd0) ? 128 : (vl == 2'd1) ? 256 : 512;
        for (int k = 0; k < 512; k++) begin
            int j = k / esz;
            if (k >= vbits) r[k] = 1'b0;
            else if (!men || m[j]) r[k] = s[k % esz];
            else r[k] = zm ? 1'b0 : od[k];
        end
        return {1'b0, r};
    endfunction

    task automatic send(string tag, logic [63:0] s, logic [511:0] od, logic [63:0] m,
                        logic men, logic zm, logic [1:0] vl, logic [7:0] opc,
                        logic w, logic [3:0] v, logic m64);
        logic [512:0] e;
        @(negedge clk);
        scalar = s; old_dst = od; mask = m; mask_en = men; zero_mode = zm;
        vl_sel = vl; opcode = opc; w_bit = w; vvvv = v; mode64 = m64;
        in_valid = 1'b1;
        e = model(s, od, m, men, zm, vl, opc, w, v, m64);
        q_dst.push_back(e[511:0]);
        q_flt.push_back(e[512]);
        q_tag.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_dst.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R10: out_valid=1 with nothing pending (expected 0)");
            end else begin
                logic [511:0] ed;
                logic         ef;
                string        t;
                ed = q_dst.pop_front(); ef = q_flt.pop_front(); t = q_tag.pop_front();
                n_vec++;
                if (dst !== ed || ud_fault !== ef) begin
                    n_bad++;
                    $display("FAIL %s: dst=%h fault=%b expected dst=%h fault=%b",
                             t, dst, ud_fault, ed, ef);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish (expected completion)");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [511:0] od1;
        od1 = {8{64'hDEAD_BEEF_0123_4567}};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0 || dst !== '0) begin
            n_bad++;
            $display("FAIL R10 reset: out_valid=%b dst=%h expected 0", out_valid, dst);
        end
        // R3: unmasked byte broadcast, full length
        send("R3 byte unmasked", 64'h1122_3344_5566_77A5, od1, '0, 0, 0, 2'd2, 8'h7A, 0, 4'hF, 1);
        idle();
        // R1: word size with merging mask
        send("R1 word merge", 64'h0000_0000_0000_BEEF, od1, 64'h0000_0000_A5A5_0F0F, 1, 0, 2'd2, 8'h7B, 0, 4'hF, 1);
        idle();
        // R4: dword merging
        send("R4 dword merge", 64'hFFFF_FFFF_CAFE_F00D, od1, 64'h0000_0000_0000_9669, 1, 0, 2'd2, 8'h7C, 0, 4'hF, 1);
        idle();
        // R5: qword zeroing, 64-bit mode W=1
        send("R5 qword zero", 64'h8765_4321_0FED_CBA9, od1, 64'h0000_0000_0000_0035, 1, 1, 2'd2, 8'h7C, 1, 4'hF, 1);
        idle();
        // R6: W ignored outside 64-bit mode
        send("R6 w ignored", 64'h8765_4321_0FED_CBA9, od1, '0, 0, 0, 2'd2, 8'h7C, 1, 4'hF, 0);
        idle();
        // R2: 128-bit length, merging, upper must clear
        send("R2 vl128", 64'h0000_0000_0000_003C, od1, 64'hFFFF_FFFF_FFFF_00F0, 1, 0, 2'd0, 8'h7A, 0, 4'hF, 1);
        idle();
        // R2: 256-bit length, zeroing
        send("R2 vl256", 64'h0000_0000_1234_5678, od1, 64'h0000_0000_0000_00A3, 1, 1, 2'd1, 8'h7C, 0, 4'hF, 1);
        idle();
        // R2: code 3 acts as 512
        send("R2 vlsel3", 64'h0000_0000_0000_7E57, od1, 64'h0000_0000_1234_5678, 1, 0, 2'd3, 8'h7B, 0, 4'hF, 1);
        idle();
        // R7: bad vvvv
        send("R7 vvvv", 64'h1, od1, '1, 0, 0, 2'd2, 8'h7A, 0, 4'hE, 1);
        idle();
        // R8: bad opcode
        send("R8 opcode", 64'h2, od1, '1, 0, 0, 2'd2, 8'h7D, 0, 4'hF, 1);
        idle();
        // R9: high mask bits ignored (qword, 128 -> 2 lanes)
        send("R9 high mask", 64'hAAAA_5555_AAAA_5555, od1, 64'hFFFF_FFFF_FFFF_FFFC, 1, 0, 2'd0, 8'h7C, 1, 4'hF, 1);
        idle();
        // R11: element layout, alternating qword mask
        send("R11 layout", 64'h0102_0304_0506_0708, od1, 64'h0000_0000_0000_0055, 1, 1, 2'd2, 8'h7C, 1, 4'hF, 1);
        idle();
        // R10: back-to-back strobes
        send("R10 b2b first", 64'h0000_0000_0000_0011, od1, '0, 0, 0, 2'd2, 8'h7A, 0, 4'hF, 1);
        send("R10 b2b second", 64'h0000_0000_0000_2222, od1, 64'h3, 1, 1, 2'd1, 8'h7B, 0, 4'hF, 1);
        idle();
        repeat (4) @(negedge clk);
        n_vec++;
        if (q_dst.size() != 0) begin
            n_bad++;
            $display("FAIL R10: %0d results missing (expected 0)", q_dst.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule